// File: doc/BRIEF.md
# MSI Coherence Directory Controller

This block is the parent end of an MSI coherence protocol for a handful of private L1 data caches, two by default. It does not hold a directory entry for every address. For each child it keeps a shadow copy of the tag and MSI state of every row of that child's cache. A line that is not present in a child's shadow row is treated as Invalid in that child. All addresses are cache-line addresses, meaning the byte address with the offset bits of a 64-byte line removed.

A child asks for more permission on a line through an upgrade request. The controller looks up every other child's shadow state for that line. It sends a downgrade request to each child whose state conflicts with the request and waits for all of their downgrade responses. Dirty data that comes back in those responses is written to memory. If the requester held nothing, the line is then read from a memory port whose latency varies. Last, the controller returns an upgrade response and records the grant in its shadow copy.

Every channel is a valid/ready pair. The controller works on one upgrade at a time, so any request that arrives during a transaction is stalled. This includes requests to the line that is busy.

Top module: `msi_dir_ctrl`

## Requirements
- R1: State codes on every port are 0 = I, 1 = S and 2 = M. The row index of a line address is its low IDX_W bits (4 by default) and the tag is the remaining upper bits. A child's state for a line is its stored state when the stored tag of that row equals the line's tag, and I otherwise. All stored states are I after reset.
- R2: `upq_ready` is high when no transaction is in progress. It stays low from the cycle after a request is accepted until the cycle after its upgrade response is accepted.
- R3: Consider each child other than the requester. When M is requested, a child holding S or M gets exactly one downgrade request with target I. When S is requested, a child holding M gets exactly one downgrade request with target S. No other child gets one, the requester never does, and `dnq_addr` is the requested line.
- R4: `ups_valid` is never high while a downgrade request is still waiting for its response, or while another child still holds a conflicting state.
- R5: An accepted downgrade response sets that child's stored state to `dnr_to`, provided the stored tag matches, and ends the wait on that child. Downgrade responses are accepted whenever no write-back is pending.
- R6: A downgrade response with `dnr_has_data` set produces one memory write of that line address and that data. The write is issued before any memory read for the same transaction.
- R7: If the requester's state was I, exactly one memory read of the line is issued, and the upgrade response has `ups_data_valid` = 1 and carries the data returned for that read. Otherwise no read is issued and `ups_data_valid` = 0.
- R8: After an upgrade response is accepted, the requester's shadow row holds the line's tag with the granted state `ups_to`, which equals the requested state.
- R9: The controller keeps `mem_rsp_ready` high while a read is outstanding. It waits any number of cycles for the read data and raises no upgrade response until that data has arrived.
- R10: While `ups_valid` is high and `ups_ready` is low, the response stays valid and its address and data do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upq_valid | input | 1 | Upgrade request valid |
| upq_ready | output | 1 | Upgrade request accepted |
| upq_child | input | CID_W | Requesting child |
| upq_addr | input | ADDR_W | Requested line address |
| upq_want | input | 2 | Requested state (S or M) |
| dnq_valid | output | 1 | Downgrade request valid |
| dnq_ready | input | 1 | Downgrade request taken |
| dnq_child | output | CID_W | Child to downgrade |
| dnq_addr | output | ADDR_W | Line to downgrade |
| dnq_to | output | 2 | Target state |
| dnr_valid | input | 1 | Downgrade response valid |
| dnr_ready | output | 1 | Downgrade response accepted |
| dnr_child | input | CID_W | Responding child |
| dnr_addr | input | ADDR_W | Line downgraded |
| dnr_to | input | 2 | State the child now holds |
| dnr_has_data | input | 1 | Response carries dirty data |
| dnr_data | input | LINE_W | Dirty line data |
| ups_valid | output | 1 | Upgrade response valid |
| ups_ready | input | 1 | Upgrade response taken |
| ups_child | output | CID_W | Child being granted |
| ups_addr | output | ADDR_W | Granted line |
| ups_to | output | 2 | Granted state |
| ups_data_valid | output | 1 | Response carries line data |
| ups_data | output | LINE_W | Line data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request taken |
| mem_req_write | output | 1 | 1 = write-back, 0 = read |
| mem_req_addr | output | ADDR_W | Memory line address |
| mem_req_data | output | LINE_W | Write-back data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Read data accepted |
| mem_rsp_data | input | LINE_W | Read data |

## Verification
The bench covers the following corner cases and the failure each one exposes.

- **Two lines in the same row with different tags.** A design that ignores the tag would send a downgrade for a line that the child no longer holds.
- **An M holder dropping to S.** The dirty data must reach memory before the requester's read. If the write is late or missing, the requester receives stale memory contents.
- **An S holder upgrading to M.** The response must carry no data, and no memory read may be issued. A design that gets this wrong either wastes a read or returns invalid data.
- **Timing and back-pressure.** Memory latency and downgrade-response delay vary, and the upgrade response is stalled for several cycles. An early response, a response that drifts while stalled, or an accepted second request would each show up at the ports.

// File: rtl/msi_dir_pkg.sv
// Shared state encoding and compatibility rules for the MSI directory controller.
// Assumes the two-bit state code is carried unchanged on every port.
package msi_dir_pkg;

    typedef enum logic [1:0] {
        MSI_I = 2'd0,
        MSI_S = 2'd1,
        MSI_M = 2'd2
    } msi_t;

    // True when a peer holding 'other' blocks a grant of 'want'.
    function automatic logic msi_conflicts(input logic [1:0] other, input logic [1:0] want);
        if (want == MSI_M) return other != MSI_I;
        return other == MSI_M;
    endfunction

    // State a conflicting peer must drop to before 'want' can be granted.
    function automatic logic [1:0] msi_dn_target(input logic [1:0] want);
        return (want == MSI_M) ? MSI_I : MSI_S;
    endfunction

endpackage

// File: rtl/msi_shadow_dir.sv
// Shadow tag/state arrays, one set per child, mirroring each child's L1 rows.
// Looks up all children at one line address in parallel. Takes one grant write
// and one downgrade write per cycle. Assumes they never target the same child.
module msi_shadow_dir
    import msi_dir_pkg::*;
#(
    parameter int N_CHILD = 2,
    parameter int ADDR_W  = 26,
    parameter int IDX_W   = 4,
    localparam int CID_W  = (N_CHILD > 1) ? $clog2(N_CHILD) : 1,
    localparam int TAG_W  = ADDR_W - IDX_W,
    localparam int ROWS   = 1 << IDX_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         lk_addr,
    output logic [N_CHILD-1:0][1:0]   lk_state,
    input  logic                      dn_we,
    input  logic [CID_W-1:0]          dn_child,
    input  logic [ADDR_W-1:0]         dn_addr,
    input  logic [1:0]                dn_state,
    input  logic                      gr_we,
    input  logic [CID_W-1:0]          gr_child,
    input  logic [ADDR_W-1:0]         gr_addr,
    input  logic [1:0]                gr_state
);

    logic [IDX_W-1:0] lk_idx, dn_idx, gr_idx;
    logic [TAG_W-1:0] lk_tag, dn_tag, gr_tag;

    // Split the three addresses into row index and tag.
    always_comb begin
        lk_idx = lk_addr[IDX_W-1:0];
        lk_tag = lk_addr[ADDR_W-1:IDX_W];
        dn_idx = dn_addr[IDX_W-1:0];
        dn_tag = dn_addr[ADDR_W-1:IDX_W];
        gr_idx = gr_addr[IDX_W-1:0];
        gr_tag = gr_addr[ADDR_W-1:IDX_W];
    end

    for (genvar c = 0; c < N_CHILD; c++) begin : g_child
        logic [TAG_W-1:0] tag_q [ROWS];
        logic [1:0]       st_q  [ROWS];
        logic             gr_hit, dn_hit;

        // Decide which write port targets this child.
        always_comb begin
            gr_hit = gr_we && (gr_child == CID_W'(c));
            dn_hit = dn_we && (dn_child == CID_W'(c)) && (tag_q[dn_idx] == dn_tag);
        end

        // Row storage: reset to I, a grant overwrites the row, a downgrade updates the state.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int r = 0; r < ROWS; r++) begin
                    tag_q[r] <= '0;
                    st_q[r]  <= MSI_I;
                end
            end else if (gr_hit) begin
                tag_q[gr_idx] <= gr_tag;
                st_q[gr_idx]  <= gr_state;
            end else if (dn_hit) begin
                st_q[dn_idx] <= dn_state;
            end
        end

        // Lookup: a tag mismatch reads as I.
        always_comb begin
            lk_state[c] = (tag_q[lk_idx] == lk_tag) ? st_q[lk_idx] : MSI_I;
        end
    end

    // R8
    one_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gr_we && dn_we && (gr_child == dn_child)));

endmodule

// File: rtl/msi_dgrade_sched.sv
// Issues downgrade requests to conflicting peers, one per cycle with the lowest
// index first, and tracks a wait flag per child until its response arrives.
// Assumes cur_state reflects the shadow directory for the line being served.
module msi_dgrade_sched
    import msi_dir_pkg::*;
#(
    parameter int N_CHILD = 2,
    localparam int CID_W  = (N_CHILD > 1) ? $clog2(N_CHILD) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      active,
    input  logic [CID_W-1:0]          req_child,
    input  logic [1:0]                want,
    input  logic [N_CHILD-1:0][1:0]   cur_state,
    output logic                      dnq_valid,
    input  logic                      dnq_ready,
    output logic [CID_W-1:0]          dnq_child,
    output logic [1:0]                dnq_to,
    input  logic                      dnr_fire,
    input  logic [CID_W-1:0]          dnr_child,
    output logic                      done,
    output logic                      wait_any
);

    logic [N_CHILD-1:0] need, wait_q;
    logic               found;

    // Peers that conflict and have not yet been asked.
    always_comb begin
        for (int j = 0; j < N_CHILD; j++) begin
            need[j] = active && (CID_W'(j) != req_child)
                      && msi_conflicts(cur_state[j], want) && !wait_q[j];
        end
    end

    // Pick the lowest-numbered peer still needing a request.
    always_comb begin
        dnq_child = '0;
        found     = 1'b0;
        for (int j = 0; j < N_CHILD; j++) begin
            if (need[j] && !found) begin
                dnq_child = CID_W'(j);
                found     = 1'b1;
            end
        end
    end

    // Request and completion outputs.
    always_comb begin
        dnq_valid = |need;
        dnq_to    = msi_dn_target(want);
        wait_any  = |wait_q;
        done      = active && !(|need) && !(|wait_q);
    end

    // Wait flags: set when a request is taken, cleared by that child's response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
        end else begin
            for (int j = 0; j < N_CHILD; j++) begin
                if (dnq_valid && dnq_ready && dnq_child == CID_W'(j))
                    wait_q[j] <= 1'b1;
                else if (dnr_fire && dnr_child == CID_W'(j))
                    wait_q[j] <= 1'b0;
            end
        end
    end

    // R3
    dn_not_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dnq_valid |-> (dnq_child != req_child));

    // R5
    dn_rsp_expected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dnr_fire |-> wait_q[dnr_child]);

endmodule

// File: rtl/msi_wb_path.sv
// Single write-back buffer for dirty downgrade data plus the memory request mux.
// A pending write-back always goes first. While it is pending, further downgrade
// responses are held off. Assumes one memory request per cycle at most.
module msi_wb_path #(
    parameter int ADDR_W = 26,
    parameter int LINE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dnr_valid,
    output logic              dnr_ready,
    input  logic              dnr_has_data,
    input  logic [ADDR_W-1:0] dnr_addr,
    input  logic [LINE_W-1:0] dnr_data,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_fire,
    output logic              wb_busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [LINE_W-1:0] mem_req_data
);

    logic              wb_full;
    logic [ADDR_W-1:0] wb_addr;
    logic [LINE_W-1:0] wb_data;

    // Memory request selection: the write-back wins over a read.
    always_comb begin
        dnr_ready     = !wb_full;
        wb_busy       = wb_full;
        mem_req_valid = wb_full || rd_req;
        mem_req_write = wb_full;
        mem_req_addr  = wb_full ? wb_addr : rd_addr;
        mem_req_data  = wb_data;
        rd_fire       = rd_req && !wb_full && mem_req_ready;
    end

    // Buffer fill on dirty response, drain on accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_full <= 1'b0;
            wb_addr <= '0;
            wb_data <= '0;
        end else if (wb_full) begin
            if (mem_req_ready) wb_full <= 1'b0;
        end else if (dnr_valid && dnr_has_data) begin
            wb_full <= 1'b1;
            wb_addr <= dnr_addr;
            wb_data <= dnr_data;
        end
    end

    // R6
    rd_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !wb_full);

endmodule

// File: rtl/msi_dir_ctrl.sv
// MSI directory controller top. It serves one upgrade request at a time:
// downgrade the conflicting peers, write back dirty data, read the line when the
// requester holds nothing, then grant. Assumes children never downgrade voluntarily.
module msi_dir_ctrl
    import msi_dir_pkg::*;
#(
    parameter int N_CHILD = 2,
    parameter int ADDR_W  = 26,
    parameter int IDX_W   = 4,
    parameter int LINE_W  = 64,
    localparam int CID_W  = (N_CHILD > 1) ? $clog2(N_CHILD) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upq_valid,
    output logic              upq_ready,
    input  logic [CID_W-1:0]  upq_child,
    input  logic [ADDR_W-1:0] upq_addr,
    input  logic [1:0]        upq_want,
    output logic              dnq_valid,
    input  logic              dnq_ready,
    output logic [CID_W-1:0]  dnq_child,
    output logic [ADDR_W-1:0] dnq_addr,
    output logic [1:0]        dnq_to,
    input  logic              dnr_valid,
    output logic              dnr_ready,
    input  logic [CID_W-1:0]  dnr_child,
    input  logic [ADDR_W-1:0] dnr_addr,
    input  logic [1:0]        dnr_to,
    input  logic              dnr_has_data,
    input  logic [LINE_W-1:0] dnr_data,
    output logic              ups_valid,
    input  logic              ups_ready,
    output logic [CID_W-1:0]  ups_child,
    output logic [ADDR_W-1:0] ups_addr,
    output logic [1:0]        ups_to,
    output logic              ups_data_valid,
    output logic [LINE_W-1:0] ups_data,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [LINE_W-1:0] mem_req_data,
    input  logic              mem_rsp_valid,
    output logic              mem_rsp_ready,
    input  logic [LINE_W-1:0] mem_rsp_data
);

    typedef enum logic [2:0] {
        PH_IDLE, PH_DGRADE, PH_MEMRD, PH_MEMWAIT, PH_GRANT
    } phase_t;

    phase_t                   phase_q;
    logic [CID_W-1:0]         req_child_q;
    logic [ADDR_W-1:0]        req_addr_q;
    logic [1:0]               req_want_q;
    logic [LINE_W-1:0]        line_q;
    logic                     dv_q;
    logic [N_CHILD-1:0][1:0]  lk_state;
    logic                     sched_done, wait_any, dnr_fire, rd_fire, wb_busy;
    logic                     rd_req, gr_we, up_fire;

    // Handshake and phase decode.
    always_comb begin
        upq_ready      = (phase_q == PH_IDLE);
        up_fire        = upq_valid && upq_ready;
        dnr_fire       = dnr_valid && dnr_ready;
        rd_req         = (phase_q == PH_MEMRD);
        mem_rsp_ready  = (phase_q == PH_MEMWAIT);
        ups_valid      = (phase_q == PH_GRANT);
        gr_we          = ups_valid && ups_ready;
        ups_child      = req_child_q;
        ups_addr       = req_addr_q;
        ups_to         = req_want_q;
        ups_data_valid = dv_q;
        ups_data       = line_q;
        dnq_addr       = req_addr_q;
    end

    msi_shadow_dir #(.N_CHILD(N_CHILD), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_addr  (req_addr_q),
        .lk_state (lk_state),
        .dn_we    (dnr_fire),
        .dn_child (dnr_child),
        .dn_addr  (dnr_addr),
        .dn_state (dnr_to),
        .gr_we    (gr_we),
        .gr_child (req_child_q),
        .gr_addr  (req_addr_q),
        .gr_state (req_want_q)
    );

    msi_dgrade_sched #(.N_CHILD(N_CHILD)) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (phase_q == PH_DGRADE),
        .req_child (req_child_q),
        .want      (req_want_q),
        .cur_state (lk_state),
        .dnq_valid (dnq_valid),
        .dnq_ready (dnq_ready),
        .dnq_child (dnq_child),
        .dnq_to    (dnq_to),
        .dnr_fire  (dnr_fire),
        .dnr_child (dnr_child),
        .done      (sched_done),
        .wait_any  (wait_any)
    );

    msi_wb_path #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_wb (
        .clk           (clk),
        .rst_n         (rst_n),
        .dnr_valid     (dnr_valid),
        .dnr_ready     (dnr_ready),
        .dnr_has_data  (dnr_has_data),
        .dnr_addr      (dnr_addr),
        .dnr_data      (dnr_data),
        .rd_req        (rd_req),
        .rd_addr       (req_addr_q),
        .rd_fire       (rd_fire),
        .wb_busy       (wb_busy),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_data  (mem_req_data)
    );

    // Transaction sequencer: accept, downgrade, fetch, grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            req_child_q <= '0;
            req_addr_q  <= '0;
            req_want_q  <= MSI_I;
            line_q      <= '0;
            dv_q        <= 1'b0;
        end else begin
            unique case (phase_q)
                PH_IDLE: if (up_fire) begin
                    req_child_q <= upq_child;
                    req_addr_q  <= upq_addr;
                    req_want_q  <= upq_want;
                    phase_q     <= PH_DGRADE;
                end
                PH_DGRADE: if (sched_done && !wb_busy) begin
                    if (lk_state[req_child_q] == MSI_I) begin
                        phase_q <= PH_MEMRD;
                    end else begin
                        dv_q    <= 1'b0;
                        phase_q <= PH_GRANT;
                    end
                end
                PH_MEMRD: if (rd_fire) phase_q <= PH_MEMWAIT;
                PH_MEMWAIT: if (mem_rsp_valid) begin
                    line_q  <= mem_rsp_data;
                    dv_q    <= 1'b1;
                    phase_q <= PH_GRANT;
                end
                PH_GRANT: if (ups_ready) phase_q <= PH_IDLE;
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // R4
    up_rsp_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ups_valid |-> !wait_any);

    // R2
    busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upq_valid && upq_ready) |=> !upq_ready);

    // R10
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ups_valid && !ups_ready) |=> (ups_valid && $stable(ups_addr) && $stable(ups_data)));

    // R7
    data_only_from_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ups_valid) && ups_data_valid |-> $past(mem_rsp_valid && mem_rsp_ready));

endmodule

// File: tb/msi_dir_ctrl_test.sv
// Bench: behavioural children, memory and directory model, checked every clock.
module msi_dir_ctrl_test;

    localparam int AW = 26;
    localparam int LW = 64;

    logic clk = 1'b0, rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          upq_valid = 0, upq_ready, upq_child = 0;
    logic [AW-1:0] upq_addr = '0;
    logic [1:0]    upq_want = '0;
    logic          dnq_valid, dnq_child;
    logic          dnq_ready = 1;
    logic [AW-1:0] dnq_addr;
    logic [1:0]    dnq_to;
    logic          dnr_valid = 0, dnr_ready, dnr_child = 0, dnr_has_data = 0;
    logic [AW-1:0] dnr_addr = '0;
    logic [1:0]    dnr_to = '0;
    logic [LW-1:0] dnr_data = '0;
    logic          ups_valid, ups_child, ups_data_valid;
    logic          ups_ready = 1;
    logic [AW-1:0] ups_addr;
    logic [1:0]    ups_to;
    logic [LW-1:0] ups_data;
    logic          mem_req_valid, mem_req_write;
    logic          mem_req_ready = 1;
    logic [AW-1:0] mem_req_addr;
    logic [LW-1:0] mem_req_data;
    logic          mem_rsp_valid = 0, mem_rsp_ready;
    logic [LW-1:0] mem_rsp_data = '0;

    msi_dir_ctrl uut (.*);

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural model state.
    int          mline [2][16];
    int          mst   [2][16];
    logic [63:0] memm  [int];
    logic [63:0] cdat  [int];
    int          data_seq = 0;

    function automatic int st_of(int j, int a);
        return (mline[j][a % 16] == a) ? mst[j][a % 16] : 0;
    endfunction
    function automatic logic [63:0] mem_val(int a);
        return memm.exists(a) ? memm[a] : (64'hA5A5_0000_0000_0000 ^ 64'(a));
    endfunction
    function automatic bit conflicts(int other, int want);
        return (want == 2) ? (other != 0) : (other == 2);
    endfunction

    // Per-transaction expectations and observations.
    int          cur_a, exp_to_g, exp_wb, hold_n;
    logic [63:0] exp_wdata;
    int          dn_cnt [2];
    int          wb_cnt, rd_seen, dn_out;
    bit          busy = 0, got_ups = 0, ups_fire_pend = 0;
    logic        cap_child, cap_dv;
    logic [AW-1:0] cap_addr;
    logic [1:0]  cap_to;
    logic [63:0] cap_data;

    // Children's pending downgrade responses.
    int          q_ch[$], q_dl[$], q_ad[$];
    logic [1:0]  q_to[$];
    bit          q_hd[$];
    logic [63:0] q_dt[$];
    bit          dn_sent = 0, rsp_on = 0, prev_stall = 0;
    int          rd_cnt = 0, lat_seq = 0, dly_seq = 0;
    logic [63:0] rd_val, prev_data;
    logic [AW-1:0] prev_addr;

    // Reference model: children, memory and per-cycle comparison at each falling edge.
    initial begin
        @(posedge rst_n);
        forever begin
            @(negedge clk);
            if (ups_fire_pend) begin busy = 0; ups_fire_pend = 0; end
            if (dn_sent) begin dnr_valid = 0; dn_sent = 0; dn_out--; end
            // R2: readiness tracks the model's busy flag every cycle
            chk(upq_ready == !busy, "R2", "upq_ready", 64'(upq_ready), 64'(!busy));
            // R4: no grant while a downgrade is outstanding
            if (ups_valid) chk(dn_out == 0, "R4", "downgrades outstanding at grant", 64'(dn_out), 0);
            // R9: no grant while read data is still in flight
            if (rd_cnt > 0) chk(!ups_valid, "R9", "grant before memory data", 64'(ups_valid), 0);
            // R10: stalled response stays put
            if (prev_stall)
                chk(ups_valid && ups_addr == prev_addr && ups_data == prev_data, "R10",
                    "stalled response changed", ups_data, prev_data);
            // Child side: drive queued downgrade responses.
            if (!dnr_valid && q_ch.size() > 0) begin
                if (q_dl[0] > 0) q_dl[0]--;
                else begin
                    dnr_valid = 1; dnr_child = 1'(q_ch[0]); dnr_addr = AW'(q_ad[0]);
                    dnr_to = q_to[0]; dnr_has_data = q_hd[0]; dnr_data = q_dt[0];
                    void'(q_ch.pop_front()); void'(q_dl.pop_front()); void'(q_ad.pop_front());
                    void'(q_to.pop_front()); void'(q_hd.pop_front()); void'(q_dt.pop_front());
                end
            end
            if (dnr_valid && dnr_ready) dn_sent = 1;
            // Child side: take downgrade requests.
            if (dnq_valid && dnq_ready) begin
                int j;
                j = int'(dnq_child);
                dn_cnt[j]++; dn_out++;
                // R3: address and target of each downgrade
                chk(int'(dnq_addr) == cur_a, "R3", "dnq_addr", 64'(dnq_addr), 64'(cur_a));
                chk(int'(dnq_to) == exp_to_g, "R3", "dnq_to", 64'(dnq_to), 64'(exp_to_g));
                q_ch.push_back(j); q_dl.push_back(dly_seq % 4); q_ad.push_back(cur_a);
                q_to.push_back(dnq_to); q_hd.push_back(st_of(j, cur_a) == 2);
                q_dt.push_back(cdat.exists(j * 2**28 + cur_a) ? cdat[j * 2**28 + cur_a] : 64'h0);
                dly_seq++;
                if (mline[j][cur_a % 16] == cur_a) mst[j][cur_a % 16] = int'(dnq_to);
            end
            // Memory side.
            if (rsp_on) begin mem_rsp_valid = 0; rsp_on = 0; end
            if (rd_cnt > 0) begin
                rd_cnt--;
                if (rd_cnt == 0) begin
                    mem_rsp_valid = 1; mem_rsp_data = rd_val; rsp_on = 1;
                    // R9
                    chk(mem_rsp_ready, "R9", "mem_rsp_ready", 64'(mem_rsp_ready), 1);
                end
            end
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_write) begin
                    wb_cnt++;
                    memm[int'(mem_req_addr)] = mem_req_data;
                    // R6: write-back address and data
                    chk(int'(mem_req_addr) == cur_a && mem_req_data == exp_wdata, "R6",
                        "write-back", mem_req_data, exp_wdata);
                end else begin
                    rd_seen++;
                    // R6: write-back precedes read
                    chk(wb_cnt == exp_wb, "R6", "writes before read", 64'(wb_cnt), 64'(exp_wb));
                    rd_val = mem_val(int'(mem_req_addr));
                    rd_cnt = 1 + (lat_seq % 7);
                    lat_seq += 3;
                end
            end
            // Core side: response back-pressure and capture.
            if (ups_valid && hold_n > 0) begin ups_ready = 0; hold_n--; end
            else ups_ready = 1;
            if (ups_valid && ups_ready) begin
                cap_child = ups_child; cap_addr = ups_addr; cap_to = ups_to;
                cap_dv = ups_data_valid; cap_data = ups_data;
                got_ups = 1; ups_fire_pend = 1;
            end
            prev_stall = ups_valid && !ups_ready;
            prev_addr = ups_addr; prev_data = ups_data;
        end
    end

    // One upgrade transaction with expectations computed from the model.
    task automatic do_req(input int c, input int a, input int want, input int hold, input string tag);
        int exp_dn [2];
        int exp_dv;
        logic [63:0] exp_data;
        exp_wb = 0; exp_wdata = '0;
        exp_to_g = (want == 2) ? 0 : 1;
        for (int j = 0; j < 2; j++) begin
            exp_dn[j] = (j != c && conflicts(st_of(j, a), want)) ? 1 : 0;
            if (j != c && st_of(j, a) == 2) begin
                exp_wb = 1;
                exp_wdata = cdat[j * 2**28 + a];
            end
        end
        exp_dv = (st_of(c, a) == 0) ? 1 : 0;
        exp_data = exp_wb ? exp_wdata : mem_val(a);
        dn_cnt[0] = 0; dn_cnt[1] = 0; wb_cnt = 0; rd_seen = 0; got_ups = 0;
        hold_n = hold; cur_a = a;
        @(negedge clk);
        upq_valid = 1; upq_child = 1'(c); upq_addr = AW'(a); upq_want = 2'(want);
        while (!upq_ready) @(negedge clk);
        @(posedge clk); busy = 1;
        @(negedge clk); upq_valid = 0;
        wait (got_ups == 1);
        @(posedge clk); @(negedge clk);
        for (int j = 0; j < 2; j++)
            chk(dn_cnt[j] == exp_dn[j], "R3", {tag, " downgrade count"}, 64'(dn_cnt[j]), 64'(exp_dn[j]));
        chk(wb_cnt == exp_wb, "R6", {tag, " write-back count"}, 64'(wb_cnt), 64'(exp_wb));
        chk(rd_seen == exp_dv, "R7", {tag, " memory reads"}, 64'(rd_seen), 64'(exp_dv));
        chk(int'(cap_dv) == exp_dv, "R7", {tag, " ups_data_valid"}, 64'(cap_dv), 64'(exp_dv));
        if (exp_dv == 1) chk(cap_data == exp_data, "R7", {tag, " ups_data"}, cap_data, exp_data);
        chk(int'(cap_child) == c && int'(cap_addr) == a, "R8", {tag, " ups child/addr"},
            64'(cap_addr), 64'(a));
        chk(int'(cap_to) == want, "R8", {tag, " ups_to"}, 64'(cap_to), 64'(want));
        mline[c][a % 16] = a; mst[c][a % 16] = want;
        if (want == 2) begin
            data_seq++;
            cdat[c * 2**28 + a] = 64'hD00D_0000_0000_0000 + 64'(data_seq);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Stimulus sequence.
    initial begin
        for (int j = 0; j < 2; j++)
            for (int r = 0; r < 16; r++) begin mline[j][r] = -1; mst[j][r] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        // R1 / R2: idle after reset
        chk(upq_ready && !ups_valid && !dnq_valid && !mem_req_valid && dnr_ready, "R1",
            "reset outputs", {59'd0, upq_ready, ups_valid, dnq_valid, mem_req_valid, dnr_ready}, 64'h11);
        do_req(0, 'h10, 1, 0, "R1 first S from I");
        do_req(1, 'h10, 1, 0, "R3 second S sharer");
        do_req(0, 'h10, 2, 0, "R5 S to M invalidates peer");
        do_req(1, 'h10, 1, 3, "R10 R6 M holder drops to S");
        do_req(1, 'h10, 2, 0, "R8 S to M after sharing");
        do_req(0, 'h21, 2, 0, "R9 fresh M other row");
        do_req(1, 'h21, 1, 2, "R6 dirty peer other row");
        do_req(1, 'h30, 1, 0, "R1 same row new tag");
        do_req(0, 'h10, 2, 0, "R1 tag mismatch no downgrade");
        do_req(1, 'h30, 2, 0, "R3 peer row holds other tag");
        do_req(0, 'h30, 1, 1, "R6 M peer to S again");
        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule